// File: doc/BRIEF.md
# Dual-Clause MDIO Management Slave

This block is the serial management slave of a PHY-style device. It runs on the management clock, samples the MDIO line on each rising edge, and decodes management frames. It then turns them into accesses on a simple parallel register port. A static strap selects the framing. With the strap low the block decodes extended-space frames: an address frame loads a held 16-bit register address, and later write, read and read-with-increment frames use that address. With the strap high it decodes direct-space frames, where a 5-bit register field in the frame selects one of registers 0 to 31.

The bidirectional MDIO line is split into an input, an output and an output enable. The block answers only frames whose 5-bit PHY address has bits [4:1] equal to four strap pins and bit [0] equal to zero. For any other frame it leaves the line released. The register side gives an address, a one-cycle write strobe and write data. It receives read data plus two flags, one saying the address is a real register and one saying it is read-only. A write to a bad target is dropped. A read from a bad target returns zero. The register contents themselves live outside the block.

Top module: `mdio_dual_slave`

## Requirements
- R1: With `mode_c22` = 0 a frame must begin with start bits 00; with `mode_c22` = 1 it must begin with 01. A frame with the other start pattern is ignored: no write strobe and no drive on MDIO.
- R2: The block acts on a frame only if PHY address bits [4:1] equal `port_pins` and PHY address bit [0] is 0. Otherwise `mdio_oe` stays 0 and no write strobe is issued.
- R3: A frame is accepted only after at least 32 consecutive 1 bits sampled on MDIO. After only 31 ones, the following frame has no effect.
- R4: Extended mode, opcode 00 (address frame): the 16-bit field, sent MSB first, is loaded into the held register address. No write strobe is issued.
- R5: Extended mode, opcode 01 (write frame): `reg_we` pulses for exactly one cycle, with `reg_wdata` equal to the frame's 16-bit field and `reg_addr` equal to the held address. `reg_addr` stays stable across the pulse.
- R6: Extended mode, opcode 11 (read) returns the register at the held address and leaves that address unchanged. Opcode 10 (read-increment) returns the same data and then advances the held address by one.
- R7: Direct mode: `reg_addr` is the 5-bit register field (frame bits 9 to 13 after the start bit) zero-extended to 16 bits. Opcode 01 writes the register and opcode 10 reads it.
- R8: A write to an address flagged invalid (`reg_valid` = 0), to a read-only address (`reg_ro` = 1), or to a wrong device address produces no write strobe.
- R9: A read from an invalid address, or with a wrong device address, returns 0x0000 on MDIO.
- R10: During a read, the block keeps MDIO released for the first turnaround bit and drives 0 for the second. It then drives the 16 data bits MSB first, each changing on the rising edge of `mdc`, and releases the line after the last bit. After reset `mdio_oe` is 0.
- R11: In extended mode only device address `DEV_ADDR` (default 1) is served. Any other device address counts as an invalid device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_c22 | input | 1 | Framing strap: 0 extended-space frames, 1 direct-space frames |
| port_pins | input | 4 | Required value of PHY address bits [4:1] |
| mdio_i | input | 1 | Sampled MDIO line |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| reg_addr | output | 16 | Register address for the device side |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data for `reg_addr` |
| reg_valid | input | 1 | `reg_addr` names an existing register |
| reg_ro | input | 1 | `reg_addr` names a read-only register |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the frame contents. It checks that the line is driven only for a frame whose latched PHY address matches the pins. It checks that every drive burst starts with a 0 turnaround bit and lasts at most 17 cycles. It also checks that write strobes are single cycles aimed at valid, writable addresses with a steady address, and that in direct mode the address never exceeds five bits. Data-dependent behaviour can only be shown by the directed scenarios: the returned read values, the post-increment of the held address, zero data for bad targets, rejection of a short preamble, and rejection of frames with the wrong start pattern for the strap.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

   typedef enum logic [0:0] {
      RX_HUNT = 1'b0,
      RX_BODY = 1'b1
   } rx_state_t;

   // Extended-space opcodes
   localparam logic [1:0] OPX_ADDR  = 2'b00;
   localparam logic [1:0] OPX_WRITE = 2'b01;
   localparam logic [1:0] OPX_RDINC = 2'b10;
   // Direct-space opcodes
   localparam logic [1:0] OPD_WRITE = 2'b01;
   localparam logic [1:0] OPD_READ  = 2'b10;

   // Header = start(2) + opcode(2) + phy addr + dev/reg addr
   function automatic int hdr_bits(input int phy_w);
      return 4 + 2 * phy_w;
   endfunction

   // Header + turnaround(2) + data
   function automatic int frm_bits(input int phy_w, input int data_w);
      return hdr_bits(phy_w) + 2 + data_w;
   endfunction

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
   parameter int PRE_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic bit_i,
   output logic pre_ok
);
   localparam int CW = $clog2(PRE_LEN + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(PRE_LEN);

   generate
      if (PRE_LEN < 2) begin : g_bad_len
         $error("mdio_pre_det: PRE_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] ones_q;

   // Counts consecutive ones while hunting; saturates at PRE_LEN
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (hold || !bit_i) begin
         ones_q <= '0;
      end else if (ones_q != CNT_TOP) begin
         ones_q <= ones_q + 1'b1;
      end
   end

   assign pre_ok = (ones_q == CNT_TOP);

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mdio_slave_pkg::*;
#(
   parameter int PHY_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   input  logic              pre_ok,
   input  logic              start_val,
   output logic              in_frame,
   output logic [$clog2(frm_bits(PHY_W, DATA_W))-1:0] idx,
   output logic              hdr_vld,
   output logic [1:0]        op_q,
   output logic [PHY_W-1:0]  pa_q,
   output logic [PHY_W-1:0]  da_q,
   output logic              end_stb,
   output logic [DATA_W-1:0] data_w
);
   localparam int HDR_BITS = hdr_bits(PHY_W);
   localparam int FRM_BITS = frm_bits(PHY_W, DATA_W);
   localparam int CW       = $clog2(FRM_BITS);
   localparam int SW       = (HDR_BITS > DATA_W) ? HDR_BITS - 1 : DATA_W - 1;
   localparam int FLD_W    = 2 * PHY_W + 2;
   localparam logic [CW-1:0] IDX_ST1 = CW'(1);
   localparam logic [CW-1:0] IDX_HDR = CW'(HDR_BITS - 1);
   localparam logic [CW-1:0] IDX_END = CW'(FRM_BITS - 1);

   rx_state_t       st_q;
   logic [SW-1:0]   sh_q;
   logic [FLD_W-1:0] fld;

   // opcode, phy address and dev/reg address as of the last header bit
   assign fld      = {sh_q[FLD_W-2:0], bit_i};
   assign in_frame = (st_q == RX_BODY);
   assign end_stb  = in_frame && (idx == IDX_END);
   assign data_w   = {sh_q[DATA_W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_HUNT;
         idx     <= '0;
         sh_q    <= '0;
         hdr_vld <= 1'b0;
         op_q    <= '0;
         pa_q    <= '0;
         da_q    <= '0;
      end else begin
         case (st_q)
            RX_HUNT: begin
               if (pre_ok && !bit_i) begin
                  st_q    <= RX_BODY;
                  idx     <= IDX_ST1;
                  sh_q    <= '0;
                  hdr_vld <= 1'b0;
               end
            end
            default: begin
               sh_q <= {sh_q[SW-2:0], bit_i};
               idx  <= idx + 1'b1;
               if (idx == IDX_ST1 && bit_i != start_val) begin
                  st_q <= RX_HUNT;
                  idx  <= '0;
               end
               if (idx == IDX_HDR) begin
                  op_q    <= fld[FLD_W-1 -: 2];
                  pa_q    <= fld[2*PHY_W-1 -: PHY_W];
                  da_q    <= fld[PHY_W-1:0];
                  hdr_vld <= 1'b1;
               end
               if (idx == IDX_END) begin
                  st_q    <= RX_HUNT;
                  idx     <= '0;
                  hdr_vld <= 1'b0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/mdio_rd_drv.sv
module mdio_rd_drv
   import mdio_slave_pkg::*;
#(
   parameter int PHY_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              in_frame,
   input  logic [$clog2(frm_bits(PHY_W, DATA_W))-1:0] idx,
   input  logic [DATA_W-1:0] word,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int HDR_BITS = hdr_bits(PHY_W);
   localparam int FRM_BITS = frm_bits(PHY_W, DATA_W);
   localparam int CW       = $clog2(FRM_BITS);
   localparam logic [CW-1:0] IDX_TA0 = CW'(HDR_BITS);
   localparam logic [CW-1:0] IDX_TA1 = CW'(HDR_BITS + 1);
   localparam logic [CW-1:0] IDX_END = CW'(FRM_BITS - 1);

   generate
      if (DATA_W < 3) begin : g_bad_w
         $error("mdio_rd_drv: DATA_W must be at least 3");
      end
   endgenerate

   logic [DATA_W-2:0] sh_q;

   // Drive value for wire bit k+1 is set at the edge that samples bit k
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
         sh_q    <= '0;
      end else if (!in_frame || !go) begin
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
      end else if (idx == IDX_TA0) begin
         mdio_oe <= 1'b1;
         mdio_o  <= 1'b0;
      end else if (idx == IDX_TA1) begin
         mdio_o <= word[DATA_W-1];
         sh_q   <= word[DATA_W-2:0];
      end else if (idx == IDX_END) begin
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
      end else if (mdio_oe) begin
         mdio_o <= sh_q[DATA_W-2];
         sh_q   <= {sh_q[DATA_W-3:0], 1'b0};
      end
   end

endmodule

// File: rtl/mdio_dual_slave.sv
module mdio_dual_slave
   import mdio_slave_pkg::*;
#(
   parameter int          PHY_W     = 5,
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int          PRE_LEN   = 32,
   parameter logic [4:0]  DEV_ADDR  = 5'd1,
   parameter bit          RD_INC_EN = 1'b1
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic              mode_c22,
   input  logic [PHY_W-2:0]  port_pins,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              reg_valid,
   input  logic              reg_ro
);
   localparam int CW = $clog2(frm_bits(PHY_W, DATA_W));

   generate
      if (PHY_W < 2 || PHY_W > 5) begin : g_bad_phy
         $error("mdio_dual_slave: PHY_W must be 2..5");
      end
      if (ADDR_W <= PHY_W || ADDR_W > DATA_W) begin : g_bad_addr
         $error("mdio_dual_slave: need PHY_W < ADDR_W <= DATA_W");
      end
   endgenerate

   logic              pre_ok, in_frame, hdr_vld, end_stb;
   logic [CW-1:0]     idx;
   logic [1:0]        op_q;
   logic [PHY_W-1:0]  pa_q, da_q;
   logic [DATA_W-1:0] data_w;
   logic [ADDR_W-1:0] held_q, held_inc;
   logic              match, dev_ok, is_rd, is_wr, is_adr, is_inc, go, act;
   logic [DATA_W-1:0] rd_word;

   mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
      .clk    (mdc),
      .rst_n  (rst_n),
      .hold   (in_frame),
      .bit_i  (mdio_i),
      .pre_ok (pre_ok)
   );

   mdio_frame_rx #(.PHY_W(PHY_W), .DATA_W(DATA_W)) u_rx (
      .clk       (mdc),
      .rst_n     (rst_n),
      .bit_i     (mdio_i),
      .pre_ok    (pre_ok),
      .start_val (mode_c22),
      .in_frame  (in_frame),
      .idx       (idx),
      .hdr_vld   (hdr_vld),
      .op_q      (op_q),
      .pa_q      (pa_q),
      .da_q      (da_q),
      .end_stb   (end_stb),
      .data_w    (data_w)
   );

   // Frame classification
   assign match  = (pa_q[PHY_W-1:1] == port_pins) && !pa_q[0];
   assign dev_ok = mode_c22 || (da_q == DEV_ADDR[PHY_W-1:0]);
   assign is_rd  = mode_c22 ? (op_q == OPD_READ) : op_q[1];
   assign is_wr  = mode_c22 ? (op_q == OPD_WRITE) : (op_q == OPX_WRITE);
   assign is_adr = !mode_c22 && (op_q == OPX_ADDR);
   assign is_inc = !mode_c22 && (op_q == OPX_RDINC);
   assign go     = hdr_vld && match && is_rd;
   assign act    = end_stb && hdr_vld && match && dev_ok;

   assign reg_addr = mode_c22 ? {{(ADDR_W-PHY_W){1'b0}}, da_q} : held_q;
   assign rd_word  = (dev_ok && reg_valid) ? reg_rdata : '0;

   generate
      if (RD_INC_EN) begin : g_inc
         assign held_inc = held_q + 1'b1;
      end else begin : g_noinc
         assign held_inc = held_q;
      end
   endgenerate

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (act) begin
            if (is_adr) begin
               held_q <= data_w[ADDR_W-1:0];
            end
            if (is_inc) begin
               held_q <= held_inc;
            end
            if (is_wr && reg_valid && !reg_ro) begin
               reg_we    <= 1'b1;
               reg_wdata <= data_w;
            end
         end
      end
   end

   mdio_rd_drv #(.PHY_W(PHY_W), .DATA_W(DATA_W)) u_drv (
      .clk      (mdc),
      .rst_n    (rst_n),
      .go       (go),
      .in_frame (in_frame),
      .idx      (idx),
      .word     (rd_word),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

endmodule

// File: rtl/mdio_dual_slave_chk.sv
module mdio_dual_slave_chk #(
   parameter int PHY_W  = 5,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_c22,
   input logic [PHY_W-2:0]  port_pins,
   input logic [PHY_W-1:0]  hdr_pa,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic              reg_valid,
   input logic              reg_ro
);
   logic [7:0] oe_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_run <= '0;
      else if (mdio_oe) oe_run <= oe_run + 1'b1;
      else oe_run <= '0;
   end

   assert_oe_only_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> (hdr_pa[PHY_W-1:1] == port_pins && !hdr_pa[0]));

   assert_ta_drives_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   assert_drive_burst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_run <= 8'(DATA_W + 1));

   assert_we_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_we_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $stable(reg_addr));

   assert_we_only_writable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_valid && !reg_ro));

   assert_direct_addr_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_c22 |-> (reg_addr[ADDR_W-1:PHY_W] == '0));

endmodule

bind mdio_dual_slave mdio_dual_slave_chk #(
   .PHY_W (PHY_W),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (mdc),
   .rst_n    (rst_n),
   .mode_c22 (mode_c22),
   .port_pins(port_pins),
   .hdr_pa   (pa_q),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .reg_addr (reg_addr),
   .reg_we   (reg_we),
   .reg_valid(reg_valid),
   .reg_ro   (reg_ro)
);

// File: tb/tb_mdio_dual_slave.sv
module tb_mdio_dual_slave;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] PA_OK = 5'b10100;
   localparam logic [3:0] PINS  = 4'b1010;
   localparam logic [4:0] DEV   = 5'd1;

   logic        mdc = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_c22 = 1'b0;
   logic        m_drv = 1'b1;
   logic        m_val = 1'b1;
   logic        mdio_i, mdio_o, mdio_oe;
   logic [15:0] reg_addr, reg_wdata, reg_rdata;
   logic        reg_we, reg_valid, reg_ro;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   bit done = 1'b0;

   logic [15:0] mem   [64];
   logic [15:0] exp_m [64];

   always #(CLK_PERIOD/2) mdc = ~mdc;

   // Line resolution with pull-up
   assign mdio_i = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);

   // Device register model: 0..63 exist, 48..63 read-only
   assign reg_valid = (reg_addr < 16'd64);
   assign reg_ro    = reg_valid && (reg_addr >= 16'd48);
   assign reg_rdata = reg_valid ? mem[reg_addr[5:0]] : 16'hDEAD;

   always @(posedge mdc) begin
      if (reg_we) begin
         we_cnt <= we_cnt + 1;
         if (reg_valid && !reg_ro) mem[reg_addr[5:0]] <= reg_wdata;
      end
   end

   mdio_dual_slave dut (
      .mdc(mdc), .rst_n(rst_n), .mode_c22(mode_c22), .port_pins(PINS),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_valid(reg_valid), .reg_ro(reg_ro)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] da,
                            input logic [15:0] val, input int pre, input bit is_rd,
                            output logic [15:0] rd, output bit wave_ok, output bit any_oe);
      logic [31:0] f;
      logic [31:0] ob_o, ob_oe;
      logic after;
      f = {st, op, pa, da, 2'b10, val};
      @(negedge mdc); m_drv = 1'b1; m_val = 1'b0;
      repeat (pre) begin @(negedge mdc); m_val = 1'b1; end
      for (int j = 0; j < 32; j++) begin
         @(negedge mdc);
         ob_oe[j] = mdio_oe;
         ob_o[j]  = mdio_o;
         if (is_rd && j >= 14) m_drv = 1'b0;
         else begin m_drv = 1'b1; m_val = f[31-j]; end
      end
      @(negedge mdc);
      after = mdio_oe;
      m_drv = 1'b1; m_val = 1'b1;
      repeat (2) @(negedge mdc);
      any_oe  = (|ob_oe) || after;
      wave_ok = !ob_oe[14] && ob_oe[15] && !ob_o[15] && (&ob_oe[31:16]) && !after;
      for (int j = 16; j < 32; j++) rd[31-j] = ob_o[j];
   endtask

   task automatic do_reset(input logic mode);
      @(negedge mdc); rst_n = 1'b0; mode_c22 = mode;
      repeat (3) @(negedge mdc);
      rst_n = 1'b1;
      @(negedge mdc);
   endtask

   task automatic xwrite(input logic [4:0] pa, input logic [4:0] da, input logic [15:0] v, input int pre);
      logic [15:0] r; bit w, a;
      run_frame(2'b00, 2'b01, pa, da, v, pre, 1'b0, r, w, a);
   endtask

   task automatic xaddr(input logic [15:0] a16);
      logic [15:0] r; bit w, a;
      run_frame(2'b00, 2'b00, PA_OK, DEV, a16, 32, 1'b0, r, w, a);
   endtask

   task automatic t_reset;
      chk("R10 reset oe", {31'd0, mdio_oe}, 32'd0);
      chk("R5 reset we", {31'd0, reg_we}, 32'd0);
   endtask

   task automatic t_ext_basic;
      logic [15:0] r; bit w, a; int c0;
      c0 = we_cnt;
      xaddr(16'd5);
      chk("R4 address frame no strobe", we_cnt - c0, 0);
      xwrite(PA_OK, DEV, 16'h1234, 32);
      exp_m[5] = 16'h1234;
      chk("R5 one strobe", we_cnt - c0, 1);
      chk("R5 stored value", {16'd0, mem[5]}, {16'd0, exp_m[5]});
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R6 read data", {16'd0, r}, {16'd0, exp_m[5]});
      chk("R10 read waveform", {31'd0, w}, 32'd1);
      chk("R11 served device", {16'd0, r}, 32'h1234);
   endtask

   task automatic t_rdinc;
      logic [15:0] r; bit w, a;
      xaddr(16'd7);
      run_frame(2'b00, 2'b10, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R6 read-inc data", {16'd0, r}, {16'd0, exp_m[7]});
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R6 after increment", {16'd0, r}, {16'd0, exp_m[8]});
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R6 plain read keeps address", {16'd0, r}, {16'd0, exp_m[8]});
   endtask

   task automatic t_match;
      logic [15:0] r; bit w, a; int c0;
      run_frame(2'b00, 2'b11, 5'b10101, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R2 pa bit0 set no drive", {31'd0, a}, 32'd0);
      run_frame(2'b00, 2'b11, 5'b00100, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R2 pin mismatch no drive", {31'd0, a}, 32'd0);
      c0 = we_cnt;
      xwrite(5'b10110, DEV, 16'h7777, 32);
      chk("R2 mismatch write ignored", we_cnt - c0, 0);
   endtask

   task automatic t_preamble;
      logic [15:0] r; bit w, a; int c0;
      xaddr(16'd10);
      c0 = we_cnt;
      xwrite(PA_OK, DEV, 16'hBEEF, 31);
      chk("R3 short preamble ignored", we_cnt - c0, 0);
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R3 value unchanged", {16'd0, r}, {16'd0, exp_m[10]});
   endtask

   task automatic t_bad_writes;
      logic [15:0] r; bit w, a; int c0;
      c0 = we_cnt;
      xaddr(16'd50);
      xwrite(PA_OK, DEV, 16'hAAAA, 32);
      chk("R8 read-only write ignored", we_cnt - c0, 0);
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R8 read-only unchanged", {16'd0, r}, {16'd0, exp_m[50]});
      xaddr(16'd100);
      xwrite(PA_OK, DEV, 16'hBBBB, 32);
      chk("R8 invalid write ignored", we_cnt - c0, 0);
      xaddr(16'd5);
      xwrite(PA_OK, 5'd2, 16'hCCCC, 32);
      chk("R8 wrong device write ignored", we_cnt - c0, 0);
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R11 register kept", {16'd0, r}, {16'd0, exp_m[5]});
   endtask

   task automatic t_bad_reads;
      logic [15:0] r; bit w, a;
      xaddr(16'd100);
      run_frame(2'b00, 2'b11, PA_OK, DEV, 16'h0, 32, 1'b1, r, w, a);
      chk("R9 invalid register reads zero", {16'd0, r}, 32'd0);
      xaddr(16'd5);
      run_frame(2'b00, 2'b11, PA_OK, 5'd3, 16'h0, 32, 1'b1, r, w, a);
      chk("R9 wrong device reads zero", {16'd0, r}, 32'd0);
      chk("R11 wrong device still drives", {31'd0, w}, 32'd1);
   endtask

   task automatic t_direct;
      logic [15:0] r; bit w, a; int c0;
      do_reset(1'b1);
      c0 = we_cnt;
      run_frame(2'b01, 2'b01, PA_OK, 5'd9, 16'h5A5A, 32, 1'b0, r, w, a);
      exp_m[9] = 16'h5A5A;
      chk("R7 direct write strobe", we_cnt - c0, 1);
      chk("R7 direct write value", {16'd0, mem[9]}, {16'd0, exp_m[9]});
      run_frame(2'b01, 2'b10, PA_OK, 5'd9, 16'h0, 32, 1'b1, r, w, a);
      chk("R7 direct read", {16'd0, r}, {16'd0, exp_m[9]});
      run_frame(2'b01, 2'b10, PA_OK, 5'd20, 16'h0, 32, 1'b1, r, w, a);
      chk("R7 direct read reg 20", {16'd0, r}, {16'd0, exp_m[20]});
      run_frame(2'b00, 2'b11, PA_OK, 5'd9, 16'h0, 32, 1'b1, r, w, a);
      chk("R1 extended frame ignored in direct mode", {31'd0, a}, 32'd0);
      do_reset(1'b0);
      run_frame(2'b01, 2'b10, PA_OK, 5'd9, 16'h0, 32, 1'b1, r, w, a);
      chk("R1 direct frame ignored in extended mode", {31'd0, a}, 32'd0);
      c0 = we_cnt;
      run_frame(2'b01, 2'b01, PA_OK, 5'd9, 16'h1111, 32, 1'b0, r, w, a);
      chk("R1 direct write ignored in extended mode", we_cnt - c0, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]   = 16'(i * 16'h0111 + 16'h1000);
         exp_m[i] = 16'(i * 16'h0111 + 16'h1000);
      end
      do_reset(1'b0);
      t_reset();
      t_ext_basic();
      t_rdinc();
      t_match();
      t_preamble();
      t_bad_writes();
      t_bad_reads();
      t_direct();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule